// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a read or write burst inside a synchronous DRAM. When a read or write command is accepted, it captures the 8-bit starting column together with the live burst configuration (length code, ordering and the single-write option). From the next cycle it presents one column address per cycle until the burst ends. It marks the final address of a finite burst with a one-cycle done flag.

Addresses follow one of two orderings. In sequential order the low bits count upward and wrap inside an aligned block whose size is the burst length. In interleaved order the low bits are the start column XOR a beat counter. A full-page burst walks all 256 columns, wraps from the top back to zero and runs until it is stopped. A terminate input ends any burst. A new command replaces the running burst on any cycle.

Control is a three-state machine. IDLE means no burst is active. FINITE means a burst of 1 to 8 beats is running. PAGE means a full-page burst is running. The transitions are:
- load: IDLE to FINITE or to PAGE on a command.
- restart: FINITE or PAGE back to FINITE or PAGE on a new command.
- finish: FINITE to IDLE after the last beat.
- halt: FINITE or PAGE to IDLE on terminate.
- hold: every other case keeps the current state.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset `col_valid`, `col_write` and `burst_done` are 0.
- R2: A command (`cmd_valid`=1) at a clock edge makes `col_valid`=1 in the following cycle, with `col_addr` equal to the captured `cmd_col` and `col_write` equal to the captured `cmd_write`.
- R3: Length code `cfg_len` selects the beat count: 3'b000=1, 3'b001=2, 3'b010=4, 3'b011=8, 3'b111=full page. A finite burst presents exactly that many addresses, one per cycle, and then `col_valid` returns to 0.
- R4: With `cfg_interleave`=0, beat k carries the start column with its low log2(BL) bits replaced by (start+k) mod BL. The upper bits are unchanged.
- R5: With `cfg_interleave`=1 and a finite length, beat k carries the start column with its low log2(BL) bits replaced by start XOR k.
- R6: In full page, beat k is (start+k) mod 256, so column 255 is followed by 0. The burst continues until a terminate or a new command arrives.
- R7: Full page with `cfg_interleave`=1 behaves exactly like a sequential full-page burst.
- R8: `burst_done` is 1 only in the cycle that carries the last address of a finite burst. It is never 1 during a full-page burst.
- R9: `cmd_stop`=1 without a command makes `col_valid` 0 in the next cycle. When no burst is active, it has no effect.
- R10: A command arriving during a burst restarts the sequence at its new column in the next cycle, on any beat. A command takes priority over a simultaneous `cmd_stop`.
- R11: With `cfg_wr_single`=1, a write command produces one address with `burst_done`=1, whatever the length code. Read commands are not affected.
- R12: The configuration is captured at the command. Changing `cfg_*` during a burst does not alter that burst.
- R13: The unused length codes 3'b100, 3'b101 and 3'b110 behave as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 3 | Burst length code |
| cfg_interleave | input | 1 | 1 = interleaved order, 0 = sequential |
| cfg_wr_single | input | 1 | 1 = writes are a single beat |
| cmd_valid | input | 1 | Read/write command strobe |
| cmd_write | input | 1 | 1 = write command, 0 = read |
| cmd_col | input | 8 | Starting column of the command |
| cmd_stop | input | 1 | Burst terminate |
| col_valid | output | 1 | A column address is presented this cycle |
| col_addr | output | 8 | Current column address |
| col_write | output | 1 | Current beat belongs to a write |
| burst_done | output | 1 | Last address of a finite burst |

## Verification
The hardest situation to reach is a restart or terminate landing on one particular beat, such as the final beat of an 8-beat interleaved burst or the 255-to-0 crossing of a full-page burst, while the configuration inputs are also changing. The random stimulus issues commands and stops at low probability, so bursts often run for many cycles and get cut at arbitrary beats. Configuration inputs are re-drawn every cycle so that R12 is exercised continuously. Directed sequences pin the wrap points, a command that collides with a stop, and single-write against each length code.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FINITE = 2'd1,
        ST_PAGE   = 2'd2
    } colgen_state_e;

    localparam logic [2:0] LEN_1    = 3'b000;
    localparam logic [2:0] LEN_2    = 3'b001;
    localparam logic [2:0] LEN_4    = 3'b010;
    localparam logic [2:0] LEN_8    = 3'b011;
    localparam logic [2:0] LEN_PAGE = 3'b111;

endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_code,
    input  logic             interleave,
    input  logic             wr_single,
    input  logic             is_write,
    output logic [COL_W-1:0] mask,
    output logic             page,
    output logic             eff_il
);
    localparam int LOG_W = 3;

    logic [LOG_W-1:0] lg;
    logic             single;

    always_comb begin
        page = 1'b0;
        lg   = '0;
        case (len_code)
            LEN_1:    lg = 3'd0;
            LEN_2:    lg = 3'd1;
            LEN_4:    lg = 3'd2;
            LEN_8:    lg = 3'd3;
            LEN_PAGE: page = 1'b1;
            default:  lg = 3'd0;
        endcase
        single = is_write && wr_single;
        for (int i = 0; i < COL_W; i++) begin
            mask[i] = !single && (page || (i < int'(lg)));
        end
        if (single) begin
            page = 1'b0;
        end
        eff_il = interleave && !page;
    end

endmodule

// File: rtl/colgen_order.sv
module colgen_order #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] cnt,
    input  logic [COL_W-1:0] mask,
    input  logic             il,
    output logic [COL_W-1:0] addr
);
    logic [COL_W-1:0] sum;

    assign sum = start + cnt;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign addr[i] = mask[i] ? (il ? (start[i] ^ cnt[i]) : sum[i]) : start[i];
    end

endmodule

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    input  logic [COL_W-1:0] dec_mask,
    input  logic             dec_page,
    input  logic             dec_il,
    output colgen_state_e    state,
    output logic [COL_W-1:0] start_q,
    output logic [COL_W-1:0] cnt_q,
    output logic [COL_W-1:0] mask_q,
    output logic             il_q,
    output logic             col_valid,
    output logic             col_write,
    output logic             burst_done
);
    colgen_state_e state_q, state_d;
    logic          wr_q;
    logic          last_beat;

    assign last_beat = (cnt_q == mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) state_d = dec_page ? ST_PAGE : ST_FINITE;
            end
            ST_FINITE: begin
                if (cmd_valid)                  state_d = dec_page ? ST_PAGE : ST_FINITE;
                else if (cmd_stop || last_beat) state_d = ST_IDLE;
            end
            ST_PAGE: begin
                if (cmd_valid)     state_d = dec_page ? ST_PAGE : ST_FINITE;
                else if (cmd_stop) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
            mask_q  <= '0;
            il_q    <= 1'b0;
            wr_q    <= 1'b0;
        end else if (cmd_valid) begin
            start_q <= cmd_col;
            cnt_q   <= '0;
            mask_q  <= dec_mask;
            il_q    <= dec_il;
            wr_q    <= cmd_write;
        end else if (state_q != ST_IDLE) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state      = state_q;
        col_valid  = (state_q != ST_IDLE);
        col_write  = col_valid && wr_q;
        burst_done = (state_q == ST_FINITE) && last_beat;
    end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_len,
    input  logic             cfg_interleave,
    input  logic             cfg_wr_single,
    input  logic             cmd_valid,
    input  logic             cmd_write,
    input  logic [COL_W-1:0] cmd_col,
    input  logic             cmd_stop,
    output logic             col_valid,
    output logic [COL_W-1:0] col_addr,
    output logic             col_write,
    output logic             burst_done
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic             dec_il;
    colgen_state_e    ctl_state;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] cnt_q;
    logic [COL_W-1:0] mask_q;
    logic             il_q;

    colgen_len_decode #(.COL_W(COL_W)) u_dec (
        .len_code   (cfg_len),
        .interleave (cfg_interleave),
        .wr_single  (cfg_wr_single),
        .is_write   (cmd_write),
        .mask       (dec_mask),
        .page       (dec_page),
        .eff_il     (dec_il)
    );

    colgen_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_write  (cmd_write),
        .cmd_col    (cmd_col),
        .cmd_stop   (cmd_stop),
        .dec_mask   (dec_mask),
        .dec_page   (dec_page),
        .dec_il     (dec_il),
        .state      (ctl_state),
        .start_q    (start_q),
        .cnt_q      (cnt_q),
        .mask_q     (mask_q),
        .il_q       (il_q),
        .col_valid  (col_valid),
        .col_write  (col_write),
        .burst_done (burst_done)
    );

    colgen_order #(.COL_W(COL_W)) u_order (
        .start (start_q),
        .cnt   (cnt_q),
        .mask  (mask_q),
        .il    (il_q),
        .addr  (col_addr)
    );

endmodule

// File: rtl/colgen_checker.sv
module colgen_checker
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_single,
    input logic             cmd_valid,
    input logic             cmd_write,
    input logic [COL_W-1:0] cmd_col,
    input logic             cmd_stop,
    input logic             col_valid,
    input logic [COL_W-1:0] col_addr,
    input logic             col_write,
    input logic             burst_done,
    input colgen_state_e    ctl_state,
    input logic [COL_W-1:0] mask_q
);
    // R2: a command is presented in the next cycle
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> col_valid && col_addr == $past(cmd_col) && col_write == $past(cmd_write));

    // R9: terminate clears the burst
    a_r9_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stop && !cmd_valid) |=> !col_valid);

    // R8: done only with a valid address
    a_r8_done_valid: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> col_valid);

    // R8: the done beat is the last one
    a_r8_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_done && !cmd_valid) |=> !col_valid);

    // R8: never done in full page
    a_r8_page_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_PAGE) |-> !burst_done);

    // R4: upper bits hold within a finite burst
    a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_FINITE && !cmd_valid && !cmd_stop && !burst_done)
        |=> ((col_addr & ~mask_q) == $past(col_addr & ~mask_q)));

    // R6: full page steps by one with wrap
    a_r6_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_state == ST_PAGE && !cmd_valid && !cmd_stop)
        |=> col_addr == COL_W'($past(col_addr) + 1'b1));

    // R11: single-write yields a one-beat burst
    a_r11_single: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_write && cfg_wr_single) |=> burst_done);

endmodule

bind sdram_burst_colgen colgen_checker #(.COL_W(COL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr_single (cfg_wr_single),
    .cmd_valid     (cmd_valid),
    .cmd_write     (cmd_write),
    .cmd_col       (cmd_col),
    .cmd_stop      (cmd_stop),
    .col_valid     (col_valid),
    .col_addr      (col_addr),
    .col_write     (col_write),
    .burst_done    (burst_done),
    .ctl_state     (ctl_state),
    .mask_q        (mask_q)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_len = 3'b000;
    logic       cfg_interleave = 1'b0;
    logic       cfg_wr_single = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [7:0] cmd_col = 8'h00;
    logic       cmd_stop = 1'b0;
    logic       col_valid;
    logic [7:0] col_addr;
    logic       col_write;
    logic       burst_done;

    int tests = 0;
    int fails = 0;

    // reference state
    bit       m_act = 0;
    bit       m_page = 0;
    bit       m_il = 0;
    bit       m_wr = 0;
    bit [7:0] m_start = 0;
    bit [7:0] m_cnt = 0;
    bit [7:0] m_mask = 0;

    always #2.5 clk = ~clk;

    sdram_burst_colgen u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_len        (cfg_len),
        .cfg_interleave (cfg_interleave),
        .cfg_wr_single  (cfg_wr_single),
        .cmd_valid      (cmd_valid),
        .cmd_write      (cmd_write),
        .cmd_col        (cmd_col),
        .cmd_stop       (cmd_stop),
        .col_valid      (col_valid),
        .col_addr       (col_addr),
        .col_write      (col_write),
        .burst_done     (burst_done)
    );

    function automatic bit [7:0] len_mask(input bit [2:0] code);
        case (code)
            3'b001:  return 8'h01;
            3'b010:  return 8'h03;
            3'b011:  return 8'h07;
            3'b111:  return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit [7:0] beat_addr(input bit [7:0] s, input bit [7:0] k,
                                           input bit [7:0] m, input bit il);
        bit [7:0] low;
        low = il ? (s ^ k) : (s + k);
        return (s & ~m) | (low & m);
    endfunction

    task automatic compare(input string tag);
        bit [7:0] ea;
        bit       ed;
        string    t;
        ea = m_act ? beat_addr(m_start, m_cnt, m_mask, m_il) : 8'h00;
        ed = m_act && !m_page && (m_cnt == m_mask);
        tests++;
        if (col_valid !== m_act || col_write !== (m_act && m_wr) || burst_done !== ed ||
            (m_act && col_addr !== ea)) begin
            fails++;
            if (tag != "") t = tag;
            else if (col_valid !== m_act) t = "R3";
            else if (burst_done !== ed) t = "R8";
            else if (col_write !== (m_act && m_wr)) t = "R2";
            else if (m_page) t = "R6";
            else if (m_il) t = "R5";
            else t = "R4";
            $display("FAIL %s: got v=%0b a=%02h w=%0b d=%0b exp v=%0b a=%02h w=%0b d=%0b",
                     t, col_valid, col_addr, col_write, burst_done,
                     m_act, ea, m_act && m_wr, ed);
        end
    endtask

    task automatic model_step();
        if (cmd_valid) begin
            m_act   = 1;
            m_start = cmd_col;
            m_cnt   = 0;
            m_wr    = cmd_write;
            m_mask  = len_mask(cfg_len);
            m_page  = (cfg_len == 3'b111);
            if (cmd_write && cfg_wr_single) begin
                m_mask = 0;
                m_page = 0;
            end
            m_il = cfg_interleave && !m_page;
        end else if (m_act) begin
            if (cmd_stop) m_act = 0;
            else if (!m_page && m_cnt == m_mask) m_act = 0;
            else m_cnt = m_cnt + 1;
        end
    endtask

    // check current outputs, then drive the next inputs
    task automatic tick(input string tag, input bit v, input bit w, input bit [7:0] c,
                        input bit st, input bit [2:0] len, input bit il, input bit sw);
        @(negedge clk);
        compare(tag);
        cmd_valid      = v;
        cmd_write      = w;
        cmd_col        = c;
        cmd_stop       = st;
        cfg_len        = len;
        cfg_interleave = il;
        cfg_wr_single  = sw;
        model_step();
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) tick(tag, 0, 0, 8'h00, 0, 3'b000, 0, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5EED_C01));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        idle("R1", 2);
        // R4 sequential 8 from 0x3D: 3D 3E 3F 38 39 3A 3B 3C
        tick("R4", 1, 0, 8'h3D, 0, 3'b011, 0, 0);
        idle("R4", 10);
        // R5 interleave 8 from 0x3D
        tick("R5", 1, 0, 8'h3D, 0, 3'b011, 1, 0);
        idle("R5", 10);
        // R3 length 2 and 4
        tick("R3", 1, 0, 8'h81, 0, 3'b001, 0, 0);
        idle("R3", 4);
        tick("R3", 1, 1, 8'h86, 0, 3'b010, 1, 0);
        idle("R3", 6);
        // R6 full page wraps 255 -> 0, then terminate (R9)
        tick("R6", 1, 0, 8'hFD, 0, 3'b111, 0, 0);
        idle("R6", 300);
        tick("R9", 0, 0, 8'h00, 1, 3'b000, 0, 0);
        idle("R9", 3);
        // R9 stop while idle
        tick("R9", 0, 0, 8'h00, 1, 3'b011, 0, 0);
        idle("R9", 2);
        // R7 interleave requested with full page
        tick("R7", 1, 0, 8'hFE, 0, 3'b111, 1, 0);
        idle("R7", 5);
        tick("R7", 0, 0, 8'h00, 1, 3'b000, 0, 0);
        idle("R7", 2);
        // R10 interrupt mid-burst, and command colliding with stop
        tick("R10", 1, 0, 8'h10, 0, 3'b011, 0, 0);
        idle("R10", 3);
        tick("R10", 1, 1, 8'h57, 1, 3'b010, 1, 0);
        idle("R10", 2);
        tick("R10", 1, 0, 8'hC4, 0, 3'b001, 0, 0);
        idle("R10", 4);
        // R11 single write across length codes; read unaffected
        for (int k = 0; k < 8; k++) begin
            tick("R11", 1, 1, 8'h23 + 8'(k), 0, 3'(k), 0, 1);
            idle("R11", 3);
        end
        tick("R11", 1, 0, 8'h23, 0, 3'b011, 0, 1);
        idle("R11", 10);
        // R12 config changes during a burst
        tick("R12", 1, 0, 8'h42, 0, 3'b011, 0, 0);
        for (int i = 0; i < 9; i++) tick("R12", 0, 0, 8'h00, 0, 3'b111, 1, 1);
        // R13 unused codes act as length 1
        for (int k = 4; k < 7; k++) begin
            tick("R13", 1, 0, 8'h99, 0, 3'(k), 1, 0);
            idle("R13", 2);
        end
        // random traffic, tags derived from what mismatched (R2..R8)
        for (int i = 0; i < 4000; i++) begin
            bit       v, st, w, il, sw;
            bit [2:0] len;
            v   = ($urandom_range(99) < 12);
            st  = ($urandom_range(99) < 4);
            w   = $urandom_range(1);
            il  = $urandom_range(1);
            sw  = ($urandom_range(3) == 0);
            len = 3'($urandom_range(7));
            tick("", v, w, 8'($urandom_range(255)), st, len, il, sw);
        end
        idle("R3", 2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule